// File: doc/BRIEF.md
# I2C Command Word Sequencer

This block sits between a transmit command queue and a byte-level I2C engine. Each queued word is 10 bits wide: an 8-bit payload plus two control flags, one asking for a start condition before the byte and one asking for a stop condition after it. The sequencer removes words from the queue one at a time and asks the byte engine for one operation at a time: start, write a byte, read a byte (acknowledged or not), or stop. Because start, stop and read length all travel inside the data stream, software only has to fill the queue.

A word carrying the start flag holds the slave address byte, whose bit 0 selects the direction. After a write address, every word without a start flag is a data byte. After a read address, the next word is a byte count, and the stop flag on that count word decides whether a stop follows the last received byte. Received bytes leave on a one-cycle push strobe. Single-cycle event strobes report a missing acknowledge (or the deliberate NACK at the end of a read), arbitration loss, and the bus returning to idle after a stop.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset, eng_req, cmd_pop, rx_push and all three event outputs are low.
- R2: A word with bit 8 set, taken while no transaction is open, produces a start operation (eng_op 0) followed by a byte write (eng_op 1) of its bits 7:0 unchanged.
- R3: After a write address, each word without bit 8 becomes one byte write of bits 7:0; a word with bit 9 set is followed by a stop operation (eng_op 3), and ev_bus_idle pulses in the cycle after the stop completes.
- R4: A single word with both bit 8 and bit 9 set produces start, address write and stop, with no data byte.
- R5: When the address byte has bit 0 set, the next word's bits 7:0 give a count N; N read operations (eng_op 2) follow, the first N-1 with eng_nack_out 0 and the last with eng_nack_out 1; each read byte appears on rx_data with rx_push in order, and ev_tx_error pulses once after the final byte.
- R6: If the count word has bit 9 clear, no stop follows the reads and the bus stays held until the next word.
- R7: A word with bit 8 set while a transaction is open produces another start operation with no stop before it.
- R8: A missing acknowledge on a written byte pulses ev_tx_error, is followed by a stop, and the remaining words of that transaction (no bit 8) are discarded.
- R9: On arbitration loss the sequencer pulses ev_arb_lost, issues no stop, drops its request, and discards words until one with bit 8 set.
- R10: If the queue empties in the middle of a write with no stop requested, the sequencer issues no operation and no stop until more words arrive.
- R11: A word without bit 8 taken while no transaction is open is removed from the queue and has no effect.
- R12: Once raised, eng_req stays high with eng_op unchanged until eng_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_empty | input | 1 | Command queue is empty |
| cmd_word | input | 10 | Head word of the queue (show-ahead) |
| cmd_pop | output | 1 | Removes the head word this cycle |
| eng_req | output | 1 | Operation request to the byte engine |
| eng_op | output | 2 | 0 start, 1 write byte, 2 read byte, 3 stop |
| eng_wdata | output | 8 | Byte to write |
| eng_nack_out | output | 1 | For reads: 1 sends NACK after the byte |
| eng_done | input | 1 | One-cycle completion of the current operation |
| eng_nack_in | input | 1 | With eng_done: written byte was not acknowledged |
| eng_arb_lost | input | 1 | With eng_done: arbitration was lost |
| eng_rdata | input | 8 | With eng_done: received byte |
| rx_push | output | 1 | rx_data holds a new received byte |
| rx_data | output | 8 | Received byte |
| ev_tx_error | output | 1 | Missing acknowledge or final read NACK |
| ev_arb_lost | output | 1 | Arbitration lost |
| ev_bus_idle | output | 1 | Bus released after a stop |

## Verification
Every result of the sequencer is registered one stage after the engine's completion: rx_push, ev_tx_error, ev_arb_lost and ev_bus_idle rise in the cycle right after the cycle in which eng_done is high, and a new engine request can appear in that same cycle. The bench samples on the falling edge and checks that each rx_push and each ev_bus_idle is preceded, exactly one sample earlier, by a completed read or stop. Operation sequences are compared once the queue and engine have both been quiet for several cycles, so the bench does not depend on the engine model's latency.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } eng_op_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_HOLD,
    SQ_START,
    SQ_SEND,
    SQ_COUNT,
    SQ_RECV,
    SQ_STOP
  } sq_state_e;
endpackage

// File: rtl/i2c_seq_decode.sv
module i2c_seq_decode #(
  parameter int BYTE_W = 8,
  localparam int CMD_W = BYTE_W + 2
) (
  input  logic [CMD_W-1:0]  word,
  output logic              has_start,
  output logic              has_stop,
  output logic              dir_read,
  output logic [BYTE_W-1:0] payload
);
  // flag positions sit directly above the payload byte
  assign has_start = word[BYTE_W];
  assign has_stop  = word[BYTE_W+1];
  assign payload   = word[BYTE_W-1:0];
  assign dir_read  = word[0];
endmodule

// File: rtl/i2c_seq_rdcount.sv
module i2c_seq_rdcount #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = load ? load_val : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == W'(1));
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_empty,
  input  logic              w_start,
  input  logic              w_stop,
  input  logic              w_read,
  input  logic [BYTE_W-1:0] w_payload,
  output logic              cmd_pop,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [BYTE_W-1:0] eng_wdata,
  output logic              eng_nack_out,
  input  logic              eng_done,
  input  logic              eng_nack_in,
  input  logic              eng_arb_lost,
  input  logic [BYTE_W-1:0] eng_rdata,
  output logic              cnt_load,
  output logic              cnt_dec,
  input  logic              cnt_last,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_data,
  output logic              ev_tx_error,
  output logic              ev_arb_lost,
  output logic              ev_bus_idle
);
  sq_state_e         st_q, st_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              stop_q, stop_d;
  logic              addr_q, addr_d;
  logic              rdir_q, rdir_d;
  logic              rstop_q, rstop_d;
  logic              fld_en, rstop_en;
  logic              push_d, err_d, arb_d, idle_d;

  // next-state process
  always_comb begin
    st_d     = st_q;
    byte_d   = byte_q;
    stop_d   = stop_q;
    addr_d   = addr_q;
    rdir_d   = rdir_q;
    rstop_d  = rstop_q;
    fld_en   = 1'b0;
    rstop_en = 1'b0;
    cmd_pop  = 1'b0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    push_d   = 1'b0;
    err_d    = 1'b0;
    arb_d    = 1'b0;
    idle_d   = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (!cmd_empty) begin
          cmd_pop = 1'b1;
          if (w_start) begin
            fld_en = 1'b1;
            byte_d = w_payload;
            stop_d = w_stop;
            addr_d = 1'b1;
            rdir_d = w_read;
            st_d   = SQ_START;
          end
        end
      end
      SQ_HOLD: begin
        if (!cmd_empty) begin
          cmd_pop = 1'b1;
          fld_en  = 1'b1;
          byte_d  = w_payload;
          stop_d  = w_stop;
          addr_d  = w_start;
          rdir_d  = w_start & w_read;
          st_d    = w_start ? SQ_START : SQ_SEND;
        end
      end
      SQ_START: begin
        if (eng_done) begin
          arb_d = eng_arb_lost;
          st_d  = eng_arb_lost ? SQ_IDLE : SQ_SEND;
        end
      end
      SQ_SEND: begin
        if (eng_done) begin
          if (eng_arb_lost) begin
            arb_d = 1'b1;
            st_d  = SQ_IDLE;
          end else if (eng_nack_in) begin
            err_d = 1'b1;
            st_d  = SQ_STOP;
          end else if (addr_q && rdir_q) begin
            st_d = SQ_COUNT;
          end else begin
            st_d = stop_q ? SQ_STOP : SQ_HOLD;
          end
        end
      end
      SQ_COUNT: begin
        if (!cmd_empty) begin
          cmd_pop  = 1'b1;
          cnt_load = 1'b1;
          rstop_en = 1'b1;
          rstop_d  = w_stop;
          if (w_payload == '0) st_d = w_stop ? SQ_STOP : SQ_HOLD;
          else                 st_d = SQ_RECV;
        end
      end
      SQ_RECV: begin
        if (eng_done) begin
          if (eng_arb_lost) begin
            arb_d = 1'b1;
            st_d  = SQ_IDLE;
          end else begin
            push_d = 1'b1;
            if (cnt_last) begin
              err_d = 1'b1;
              st_d  = rstop_q ? SQ_STOP : SQ_HOLD;
            end else begin
              cnt_dec = 1'b1;
            end
          end
        end
      end
      SQ_STOP: begin
        if (eng_done) begin
          arb_d  = eng_arb_lost;
          idle_d = !eng_arb_lost;
          st_d   = SQ_IDLE;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= SQ_IDLE;
      byte_q      <= '0;
      stop_q      <= 1'b0;
      addr_q      <= 1'b0;
      rdir_q      <= 1'b0;
      rstop_q     <= 1'b0;
      rx_push     <= 1'b0;
      rx_data     <= '0;
      ev_tx_error <= 1'b0;
      ev_arb_lost <= 1'b0;
      ev_bus_idle <= 1'b0;
    end else begin
      st_q        <= st_d;
      rx_push     <= push_d;
      ev_tx_error <= err_d;
      ev_arb_lost <= arb_d;
      ev_bus_idle <= idle_d;
      if (fld_en) begin
        byte_q <= byte_d;
        stop_q <= stop_d;
        addr_q <= addr_d;
        rdir_q <= rdir_d;
      end
      if (rstop_en) rstop_q <= rstop_d;
      if (push_d)   rx_data <= eng_rdata;
    end
  end

  // engine request decode
  always_comb begin
    eng_req = 1'b1;
    eng_op  = OP_START;
    unique case (st_q)
      SQ_START: eng_op = OP_START;
      SQ_SEND:  eng_op = OP_WRITE;
      SQ_RECV:  eng_op = OP_READ;
      SQ_STOP:  eng_op = OP_STOP;
      default:  eng_req = 1'b0;
    endcase
  end
  assign eng_wdata    = byte_q;
  assign eng_nack_out = (st_q == SQ_RECV) && cnt_last;

  // R12: a pending request does not move before it completes
  p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_done |=> eng_req && $stable(eng_op));

  // R5: a received byte is only pushed after a completed read
  p_push_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> $past(eng_done && !eng_arb_lost && eng_op == OP_READ));

  // R3: bus idle only follows a completed stop
  p_idle_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_idle |-> $past(eng_done && !eng_arb_lost && eng_op == OP_STOP));

  // R9: after arbitration loss nothing is requested
  p_abandon_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost |-> !eng_req);

  // R8: error events come from a NACK seen or a final read
  p_err_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_error |-> $past(eng_done && !eng_arb_lost &&
                          (eng_nack_in || eng_op == OP_READ)));

  // R5: NACK is only sent on a read
  p_nack_only_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_nack_out |-> eng_req && eng_op == OP_READ);
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq #(
  parameter int BYTE_W = 8,
  localparam int CMD_W = BYTE_W + 2,
  localparam int CNT_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_empty,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic              cmd_pop,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [BYTE_W-1:0] eng_wdata,
  output logic              eng_nack_out,
  input  logic              eng_done,
  input  logic              eng_nack_in,
  input  logic              eng_arb_lost,
  input  logic [BYTE_W-1:0] eng_rdata,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_data,
  output logic              ev_tx_error,
  output logic              ev_arb_lost,
  output logic              ev_bus_idle
);
  logic              w_start, w_stop, w_read;
  logic [BYTE_W-1:0] w_payload;
  logic              cnt_load, cnt_dec, cnt_last;

  i2c_seq_decode #(.BYTE_W(BYTE_W)) u_dec (
    .word      (cmd_word),
    .has_start (w_start),
    .has_stop  (w_stop),
    .dir_read  (w_read),
    .payload   (w_payload)
  );

  i2c_seq_rdcount #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .dec      (cnt_dec),
    .load_val (w_payload),
    .last     (cnt_last)
  );

  i2c_seq_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_empty    (cmd_empty),
    .w_start      (w_start),
    .w_stop       (w_stop),
    .w_read       (w_read),
    .w_payload    (w_payload),
    .cmd_pop      (cmd_pop),
    .eng_req      (eng_req),
    .eng_op       (eng_op),
    .eng_wdata    (eng_wdata),
    .eng_nack_out (eng_nack_out),
    .eng_done     (eng_done),
    .eng_nack_in  (eng_nack_in),
    .eng_arb_lost (eng_arb_lost),
    .eng_rdata    (eng_rdata),
    .cnt_load     (cnt_load),
    .cnt_dec      (cnt_dec),
    .cnt_last     (cnt_last),
    .rx_push      (rx_push),
    .rx_data      (rx_data),
    .ev_tx_error  (ev_tx_error),
    .ev_arb_lost  (ev_arb_lost),
    .ev_bus_idle  (ev_bus_idle)
  );
endmodule

// File: tb/i2c_cmd_seq_test.sv
`timescale 1ns/1ps
module i2c_cmd_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_empty, cmd_pop;
  logic [9:0] cmd_word;
  logic       eng_req, eng_nack_out;
  logic [1:0] eng_op;
  logic [7:0] eng_wdata;
  logic       eng_done = 1'b0, eng_nack_in = 1'b0, eng_arb_lost = 1'b0;
  logic [7:0] eng_rdata = 8'h00;
  logic       rx_push, ev_tx_error, ev_arb_lost, ev_bus_idle;
  logic [7:0] rx_data;

  always #4 clk = ~clk;

  i2c_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_empty(cmd_empty), .cmd_word(cmd_word),
    .cmd_pop(cmd_pop), .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
    .eng_nack_out(eng_nack_out), .eng_done(eng_done), .eng_nack_in(eng_nack_in),
    .eng_arb_lost(eng_arb_lost), .eng_rdata(eng_rdata), .rx_push(rx_push),
    .rx_data(rx_data), .ev_tx_error(ev_tx_error), .ev_arb_lost(ev_arb_lost),
    .ev_bus_idle(ev_bus_idle)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // command queue model (show-ahead)
  logic [9:0] fq [0:255];
  logic [7:0] rd_p = 8'd0, wr_p = 8'd0;
  assign cmd_empty = (rd_p == wr_p);
  assign cmd_word  = fq[rd_p];
  always @(posedge clk) if (cmd_pop) rd_p <= rd_p + 8'd1;

  task automatic push(input logic [9:0] w);
    @(negedge clk);
    fq[wr_p] = w;
    wr_p = wr_p + 8'd1;
  endtask

  // byte engine model with scripted responses
  logic [1:0] op_log   [0:255];
  logic [7:0] byte_log [0:255];
  logic       ack_log  [0:255];
  int op_n = 0;
  int arb_at = -1, nack_at = -1;
  int e_ph = 0, e_cnt = 0;
  logic cur_arb = 1'b0, cur_nack = 1'b0;

  always @(posedge clk) begin
    if (rst_n) begin
      case (e_ph)
        0: if (eng_req) begin
          op_log[op_n[7:0]]   <= eng_op;
          byte_log[op_n[7:0]] <= eng_wdata;
          ack_log[op_n[7:0]]  <= eng_nack_out;
          cur_arb  <= (op_n == arb_at);
          cur_nack <= (eng_op == 2'd1) && (op_n == nack_at);
          eng_rdata <= 8'hC0 + op_n[7:0];
          op_n  <= op_n + 1;
          e_cnt <= 2;
          e_ph  <= 1;
        end
        1: if (e_cnt == 0) begin
          eng_done     <= 1'b1;
          eng_arb_lost <= cur_arb;
          eng_nack_in  <= cur_nack;
          e_ph         <= 2;
        end else e_cnt <= e_cnt - 1;
        default: begin
          eng_done     <= 1'b0;
          eng_arb_lost <= 1'b0;
          eng_nack_in  <= 1'b0;
          e_ph         <= 0;
        end
      endcase
    end
  end

  // output monitor, sampled on the falling edge
  logic [7:0] rx_log [0:255];
  int rx_n = 0, n_idle = 0, n_err = 0, n_arb = 0;
  bit prev_stop_done = 1'b0, prev_rd_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_push) begin
        rx_log[rx_n[7:0]] = rx_data;
        rx_n++;
        chk(prev_rd_done, "R5 rx_push one cycle after read done", 0, 1);
      end
      if (ev_bus_idle) begin
        n_idle++;
        chk(prev_stop_done, "R3 bus idle one cycle after stop done", 0, 1);
      end
      if (ev_tx_error) n_err++;
      if (ev_arb_lost) n_arb++;
      prev_stop_done = eng_done && !eng_arb_lost && eng_op == 2'd3;
      prev_rd_done   = eng_done && !eng_arb_lost && eng_op == 2'd2;
    end
  end

  task automatic settle();
    int quiet = 0;
    while (quiet < 12) begin
      @(negedge clk);
      if (!eng_req && e_ph == 0 && (cmd_empty || !cmd_pop)) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic exp_op(input int idx, input logic [1:0] op, input logic [7:0] b,
                        input string tag);
    chk(op_log[idx[7:0]] == op, {tag, " op code"}, op_log[idx[7:0]], op);
    if (op == 2'd1)
      chk(byte_log[idx[7:0]] == b, {tag, " written byte"}, byte_log[idx[7:0]], b);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!eng_req && !cmd_pop && !rx_push, "R1 outputs low after reset",
        {eng_req, cmd_pop, rx_push}, 0);
    chk(!ev_tx_error && !ev_arb_lost && !ev_bus_idle, "R1 events low after reset",
        {ev_tx_error, ev_arb_lost, ev_bus_idle}, 0);
  endtask

  task automatic t_write();
    int b = op_n, i0 = n_idle, e0 = n_err;
    push(10'h1A0); push(10'h011); push(10'h222);
    settle();
    exp_op(b, 2'd0, 8'h00, "R2 start");
    exp_op(b + 1, 2'd1, 8'hA0, "R2 address");
    exp_op(b + 2, 2'd1, 8'h11, "R3 data 1");
    exp_op(b + 3, 2'd1, 8'h22, "R3 data 2");
    exp_op(b + 4, 2'd3, 8'h00, "R3 stop");
    chk(op_n - b == 5, "R3 op count", op_n - b, 5);
    chk(n_idle - i0 == 1, "R3 bus idle once", n_idle - i0, 1);
    chk(n_err == e0, "R3 no error", n_err - e0, 0);
  endtask

  task automatic t_drop_idle();
    int b = op_n;
    push(10'h055);
    settle();
    chk(op_n == b, "R11 stray word gives no op", op_n - b, 0);
    chk(cmd_empty, "R11 stray word removed", wr_p - rd_p, 0);
  endtask

  task automatic t_addr_only();
    int b = op_n, i0 = n_idle;
    push(10'h3A0);
    settle();
    exp_op(b, 2'd0, 8'h00, "R4 start");
    exp_op(b + 1, 2'd1, 8'hA0, "R4 address");
    exp_op(b + 2, 2'd3, 8'h00, "R4 stop");
    chk(op_n - b == 3, "R4 op count", op_n - b, 3);
    chk(n_idle - i0 == 1, "R4 bus idle", n_idle - i0, 1);
  endtask

  task automatic t_read();
    int b = op_n, r0 = rx_n, e0 = n_err, i0 = n_idle;
    push(10'h1A1); push(10'h203);
    settle();
    exp_op(b, 2'd0, 8'h00, "R5 start");
    exp_op(b + 1, 2'd1, 8'hA1, "R5 address");
    for (int k = 0; k < 3; k++) begin
      exp_op(b + 2 + k, 2'd2, 8'h00, "R5 read");
      chk(ack_log[(b + 2 + k) % 256] == (k == 2), "R5 ack/nack choice",
          ack_log[(b + 2 + k) % 256], (k == 2));
      chk(rx_log[(r0 + k) % 256] == 8'(8'hC0 + (b + 2 + k)), "R5 received byte",
          rx_log[(r0 + k) % 256], 8'(8'hC0 + (b + 2 + k)));
    end
    exp_op(b + 5, 2'd3, 8'h00, "R5 stop");
    chk(rx_n - r0 == 3, "R5 push count", rx_n - r0, 3);
    chk(n_err - e0 == 1, "R5 final nack event", n_err - e0, 1);
    chk(n_idle - i0 == 1, "R5 bus idle", n_idle - i0, 1);
  endtask

  task automatic t_rstart();
    int b = op_n, i0 = n_idle;
    push(10'h1A0); push(10'h055); push(10'h1A1); push(10'h002);
    settle();
    exp_op(b + 2, 2'd1, 8'h55, "R7 data before restart");
    exp_op(b + 3, 2'd0, 8'h00, "R7 repeated start");
    exp_op(b + 4, 2'd1, 8'hA1, "R7 read address");
    exp_op(b + 6, 2'd2, 8'h00, "R6 last read");
    chk(op_n - b == 7, "R6 no stop after reads", op_n - b, 7);
    chk(n_idle == i0, "R6 bus held", n_idle - i0, 0);
    push(10'h3B0);
    settle();
    exp_op(b + 7, 2'd0, 8'h00, "R7 start after held read");
    exp_op(b + 8, 2'd1, 8'hB0, "R7 address");
    exp_op(b + 9, 2'd3, 8'h00, "R7 stop");
    chk(n_idle - i0 == 1, "R7 bus idle", n_idle - i0, 1);
  endtask

  task automatic t_nack();
    int b = op_n, e0 = n_err, i0 = n_idle;
    nack_at = b + 1;
    push(10'h1A0); push(10'h077); push(10'h288);
    settle();
    nack_at = -1;
    exp_op(b + 2, 2'd3, 8'h00, "R8 stop after nack");
    chk(op_n - b == 3, "R8 later words dropped", op_n - b, 3);
    chk(n_err - e0 == 1, "R8 error event", n_err - e0, 1);
    chk(n_idle - i0 == 1, "R8 bus idle", n_idle - i0, 1);
    chk(cmd_empty, "R8 words removed", wr_p - rd_p, 0);
  endtask

  task automatic t_arb();
    int b = op_n, a0 = n_arb, i0 = n_idle;
    arb_at = b + 2;
    push(10'h1A0); push(10'h0AA); push(10'h2BB); push(10'h3C0);
    settle();
    arb_at = -1;
    chk(n_arb - a0 == 1, "R9 arb event", n_arb - a0, 1);
    exp_op(b + 3, 2'd0, 8'h00, "R9 next start after loss");
    exp_op(b + 4, 2'd1, 8'hC0, "R9 next address");
    exp_op(b + 5, 2'd3, 8'h00, "R9 stop of next transaction");
    chk(op_n - b == 6, "R9 no stop, stray word dropped", op_n - b, 6);
    chk(n_idle - i0 == 1, "R9 one bus idle", n_idle - i0, 1);
  endtask

  task automatic t_underflow();
    int b = op_n, i0 = n_idle;
    push(10'h1A0); push(10'h012);
    settle();
    repeat (40) @(negedge clk);
    chk(op_n - b == 3, "R10 no op while starved", op_n - b, 3);
    chk(!eng_req, "R10 no request while starved", eng_req, 0);
    chk(n_idle == i0, "R10 bus still held", n_idle - i0, 0);
    push(10'h234);
    settle();
    exp_op(b + 3, 2'd1, 8'h34, "R10 resumed data");
    exp_op(b + 4, 2'd3, 8'h00, "R10 stop");
    chk(n_idle - i0 == 1, "R10 bus idle", n_idle - i0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write();
    t_drop_idle();
    t_addr_only();
    t_read();
    t_rstart();
    t_nack();
    t_arb();
    t_underflow();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule